// File: doc/BRIEF.md
# Stream-Detecting Data Prefetcher

This block sits beside a lower-level cache and watches the stream of demand miss addresses that cache sends to memory. It keeps a small table of page trackers, one per 4 KB page, and decides from the pattern of misses inside a page whether a sequential stream is running there. When a stream is confirmed, the block produces block-aligned prefetch addresses that step one cache block at a time in the stream's direction. The cache fetches those blocks into its own storage; the block itself holds no data.

Each tracker needs two misses in its page before anything is issued. The first miss creates the tracker in a training state. A later miss to the same page that lands fewer than 256 bytes away (one to three 64-byte blocks) confirms a stream. The sign of the gap sets the direction. Requests go out only while memory reports that it is idle and no demand miss is being presented, so demand traffic always has priority. When all eight trackers are in use, a miss to a new page takes over the least recently touched tracker.

Top module: `streamPrefetcher`

## Requirements
- R1: After reset no prefetch request is pending (pfValid low) and every tracker is empty, so no request appears until a page has seen two qualifying misses.
- R2: A single miss to a page only creates a training tracker; with memory idle, no prefetch is issued for that page.
- R3: A second miss to a page with a training tracker confirms a stream only if the block distance (address bits [11:6]) is 1, 2 or 3; a distance of 0 or of 4 or more leaves the tracker training, and the newest miss block becomes the reference for the next comparison.
- R4: A confirmed stream issues block addresses starting one block past the triggering miss, ascending when the second miss was above the first and descending when it was below, one block per request.
- R5: A stream stops issuing after it has requested the last block of its page in its direction (block 63 going up, block 0 going down) and never produces an address in another page.
- R6: A new request is loaded only in a cycle where memIdle is high, missValid is low and no request is pending.
- R7: A pending request holds pfValid high and pfAddr unchanged until pfReady is high, including cycles with unrelated demand misses.
- R8: If a demand miss falls in the same 64-byte block as the pending request, the request is withdrawn: pfValid is low in the following cycle without a handshake.
- R9: Up to eight pages are tracked; a miss to an untracked page uses a free tracker first, otherwise it replaces the tracker least recently touched by a miss, which loses its history.
- R10: A miss to a page with an active stream re-anchors that stream: the next request is the block one step past that miss in the stream's direction.
- R11: pfAddr carries the page number in bits [31:12], the block index in bits [11:6] and zeros in bits [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | A demand miss address is presented this cycle |
| missAddr | input | 32 | Byte address of the demand miss |
| memIdle | input | 1 | Memory has spare bandwidth for a prefetch |
| pfValid | output | 1 | A prefetch request is pending |
| pfAddr | output | 32 | Block-aligned byte address of the pending prefetch |
| pfReady | input | 1 | Memory accepts the pending prefetch this cycle |

## Verification
A tracker holding the wrong reference block or direction shows up as a prefetch sequence that starts at the wrong block, runs the wrong way, or appears for a page that should still be training; the scoreboard sees this at the first handshake after memory goes idle. A wrong replacement choice stays hidden until the evicted page is missed again, so the bench follows a fill of all eight trackers with misses to both the expected victim and a survivor. A broken boundary or cancel rule appears within a cycle or two as an extra request past the page end or a request that fails to drop after a matching miss.

// File: rtl/pfPkg.sv
package pfPkg;
  // Control-to-datapath strobes for one cycle
  typedef struct packed {
    logic missHit;   // miss lands in a tracked page
    logic activate;  // training tracker becomes a stream
    logic dirUp;     // direction chosen on activation
    logic alloc;     // miss claims a new tracker
    logic issue;     // load the request register
    logic cancel;    // pending request duplicates the miss
  } pfStrobe_t;
endpackage

// File: rtl/pfCtrl.sv
module pfCtrl
  import pfPkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int IDX_W       = 3,
  parameter int PAGE_NUM_W  = 20,
  parameter int BLK_IDX_W   = 6,
  parameter int TRIG_BLKS   = 4
) (
  input  logic                  missValid,
  input  logic [PAGE_NUM_W-1:0] missPage,
  input  logic [BLK_IDX_W-1:0]  missBlk,
  input  logic                  memIdle,
  input  logic                  pfValid,
  input  logic [PAGE_NUM_W-1:0] pfPage,
  input  logic [BLK_IDX_W-1:0]  pfBlk,
  input  logic                  trkVld  [NUM_STREAMS],
  input  logic                  trkAct  [NUM_STREAMS],
  input  logic                  trkPend [NUM_STREAMS],
  input  logic [PAGE_NUM_W-1:0] trkPage [NUM_STREAMS],
  input  logic [BLK_IDX_W-1:0]  trkLast [NUM_STREAMS],
  input  logic [IDX_W-1:0]      trkAge  [NUM_STREAMS],
  output pfStrobe_t             strobe,
  output logic [IDX_W-1:0]      hitIdx,
  output logic [IDX_W-1:0]      allocIdx,
  output logic [IDX_W-1:0]      issueIdx
);
  localparam logic [IDX_W-1:0]   OLDEST = IDX_W'(NUM_STREAMS - 1);
  localparam logic [BLK_IDX_W:0] TRIG_L = (BLK_IDX_W + 1)'(TRIG_BLKS);

  logic                   hit, anyFree, anyCand, near, dup;
  logic [IDX_W-1:0]       freeIdx, lruIdx;
  logic signed [BLK_IDX_W:0] delta, mag;

  // Lowest index wins every search (loop runs downward)
  always_comb begin
    hit = 1'b0; hitIdx = '0; anyFree = 1'b0; freeIdx = '0;
    lruIdx = '0; anyCand = 1'b0; issueIdx = '0;
    for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
      if (trkVld[i] && trkPage[i] == missPage) begin
        hit = 1'b1; hitIdx = IDX_W'(i);
      end
      if (!trkVld[i]) begin
        anyFree = 1'b1; freeIdx = IDX_W'(i);
      end
      if (trkAge[i] == OLDEST) lruIdx = IDX_W'(i);
      if (trkVld[i] && trkAct[i] && trkPend[i]) begin
        anyCand = 1'b1; issueIdx = IDX_W'(i);
      end
    end
  end

  assign allocIdx = anyFree ? freeIdx : lruIdx;

  // Block distance between this miss and the tracker's reference
  always_comb begin
    delta = $signed({1'b0, missBlk}) - $signed({1'b0, trkLast[hitIdx]});
    mag   = delta[BLK_IDX_W] ? -delta : delta;
  end
  assign near = (mag != '0) && ($unsigned(mag) < TRIG_L);
  assign dup  = pfValid && missValid && ({missPage, missBlk} == {pfPage, pfBlk});

  always_comb begin
    strobe.missHit  = missValid && hit;
    strobe.activate = missValid && hit && !trkAct[hitIdx] && near;
    strobe.dirUp    = !delta[BLK_IDX_W];
    strobe.alloc    = missValid && !hit;
    strobe.issue    = memIdle && !pfValid && !missValid && anyCand;
    strobe.cancel   = dup;
  end
endmodule

// File: rtl/pfDatapath.sv
module pfDatapath
  import pfPkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int IDX_W       = 3,
  parameter int PAGE_NUM_W  = 20,
  parameter int BLK_IDX_W   = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pfStrobe_t             strobe,
  input  logic [IDX_W-1:0]      hitIdx,
  input  logic [IDX_W-1:0]      allocIdx,
  input  logic [IDX_W-1:0]      issueIdx,
  input  logic [PAGE_NUM_W-1:0] missPage,
  input  logic [BLK_IDX_W-1:0]  missBlk,
  input  logic                  pfReady,
  output logic                  trkVld  [NUM_STREAMS],
  output logic                  trkAct  [NUM_STREAMS],
  output logic                  trkPend [NUM_STREAMS],
  output logic [PAGE_NUM_W-1:0] trkPage [NUM_STREAMS],
  output logic [BLK_IDX_W-1:0]  trkLast [NUM_STREAMS],
  output logic [IDX_W-1:0]      trkAge  [NUM_STREAMS],
  output logic                  pfValid,
  output logic [PAGE_NUM_W-1:0] pfPage,
  output logic [BLK_IDX_W-1:0]  pfBlk
);
  logic                 trkDir  [NUM_STREAMS];
  logic [BLK_IDX_W-1:0] trkNext [NUM_STREAMS];

  // Returns {stillInPage, nextBlock}
  function automatic logic [BLK_IDX_W:0] stepBlk(input logic [BLK_IDX_W-1:0] b,
                                                 input logic up);
    if (up) return {b != '1, b + 1'b1};
    else    return {b != '0, b - 1'b1};
  endfunction

  logic                 touch, hitDir;
  logic [IDX_W-1:0]     touchIdx;
  logic [BLK_IDX_W:0]   hitStep, issStep;

  assign touch    = strobe.missHit || strobe.alloc;
  assign touchIdx = strobe.missHit ? hitIdx : allocIdx;
  assign hitDir   = trkAct[hitIdx] ? trkDir[hitIdx] : strobe.dirUp;
  assign hitStep  = stepBlk(missBlk, hitDir);
  assign issStep  = stepBlk(trkNext[issueIdx], trkDir[issueIdx]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        trkVld[i]  <= 1'b0;
        trkAct[i]  <= 1'b0;
        trkPend[i] <= 1'b0;
        trkDir[i]  <= 1'b0;
        trkPage[i] <= '0;
        trkLast[i] <= '0;
        trkNext[i] <= '0;
        trkAge[i]  <= IDX_W'(i);
      end
    end else begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        if (touch) begin
          if (IDX_W'(i) == touchIdx)              trkAge[i] <= '0;
          else if (trkAge[i] < trkAge[touchIdx])  trkAge[i] <= trkAge[i] + 1'b1;
        end
        if (strobe.alloc && IDX_W'(i) == allocIdx) begin
          trkVld[i]  <= 1'b1;
          trkAct[i]  <= 1'b0;
          trkPend[i] <= 1'b0;
          trkPage[i] <= missPage;
          trkLast[i] <= missBlk;
        end
        if (strobe.missHit && IDX_W'(i) == hitIdx) begin
          trkLast[i] <= missBlk;
          if (trkAct[i] || strobe.activate) begin
            trkAct[i]  <= 1'b1;
            trkDir[i]  <= hitDir;
            trkPend[i] <= hitStep[BLK_IDX_W];
            trkNext[i] <= hitStep[BLK_IDX_W-1:0];
          end
        end
        if (strobe.issue && IDX_W'(i) == issueIdx) begin
          trkPend[i] <= issStep[BLK_IDX_W];
          trkNext[i] <= issStep[BLK_IDX_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pfValid <= 1'b0;
      pfPage  <= '0;
      pfBlk   <= '0;
    end else if (pfValid) begin
      if (pfReady || strobe.cancel) pfValid <= 1'b0;
    end else if (strobe.issue) begin
      pfValid <= 1'b1;
      pfPage  <= trkPage[issueIdx];
      pfBlk   <= trkNext[issueIdx];
    end
  end
endmodule

// File: rtl/streamPrefetcher.sv
module streamPrefetcher
  import pfPkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int BLOCK_BYTES   = 64,
  parameter int PAGE_BYTES    = 4096,
  parameter int TRIGGER_BYTES = 256,
  parameter int NUM_STREAMS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              memIdle,
  output logic              pfValid,
  output logic [ADDR_W-1:0] pfAddr,
  input  logic              pfReady
);
  localparam int OFF_W      = $clog2(BLOCK_BYTES);
  localparam int PAGE_OFF_W = $clog2(PAGE_BYTES);
  localparam int BLK_IDX_W  = PAGE_OFF_W - OFF_W;
  localparam int PAGE_NUM_W = ADDR_W - PAGE_OFF_W;
  localparam int IDX_W      = $clog2(NUM_STREAMS);
  localparam int TRIG_BLKS  = TRIGGER_BYTES / BLOCK_BYTES;

  logic [PAGE_NUM_W-1:0] missPage, pfPage;
  logic [BLK_IDX_W-1:0]  missBlk, pfBlk;
  pfStrobe_t             strobe;
  logic [IDX_W-1:0]      hitIdx, allocIdx, issueIdx;

  logic                  trkVld  [NUM_STREAMS];
  logic                  trkAct  [NUM_STREAMS];
  logic                  trkPend [NUM_STREAMS];
  logic [PAGE_NUM_W-1:0] trkPage [NUM_STREAMS];
  logic [BLK_IDX_W-1:0]  trkLast [NUM_STREAMS];
  logic [IDX_W-1:0]      trkAge  [NUM_STREAMS];

  assign missPage = missAddr[ADDR_W-1:PAGE_OFF_W];
  assign missBlk  = missAddr[PAGE_OFF_W-1:OFF_W];
  assign pfAddr   = {pfPage, pfBlk, {OFF_W{1'b0}}};

  pfCtrl #(
    .NUM_STREAMS(NUM_STREAMS), .IDX_W(IDX_W), .PAGE_NUM_W(PAGE_NUM_W),
    .BLK_IDX_W(BLK_IDX_W), .TRIG_BLKS(TRIG_BLKS)
  ) u_ctrl (
    .missValid(missValid), .missPage(missPage), .missBlk(missBlk),
    .memIdle(memIdle), .pfValid(pfValid), .pfPage(pfPage), .pfBlk(pfBlk),
    .trkVld(trkVld), .trkAct(trkAct), .trkPend(trkPend), .trkPage(trkPage),
    .trkLast(trkLast), .trkAge(trkAge), .strobe(strobe), .hitIdx(hitIdx),
    .allocIdx(allocIdx), .issueIdx(issueIdx)
  );

  pfDatapath #(
    .NUM_STREAMS(NUM_STREAMS), .IDX_W(IDX_W), .PAGE_NUM_W(PAGE_NUM_W),
    .BLK_IDX_W(BLK_IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hitIdx(hitIdx),
    .allocIdx(allocIdx), .issueIdx(issueIdx), .missPage(missPage),
    .missBlk(missBlk), .pfReady(pfReady), .trkVld(trkVld), .trkAct(trkAct),
    .trkPend(trkPend), .trkPage(trkPage), .trkLast(trkLast), .trkAge(trkAge),
    .pfValid(pfValid), .pfPage(pfPage), .pfBlk(pfBlk)
  );
endmodule

// File: rtl/streamPrefetcherChk.sv
module streamPrefetcherChk #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic [ADDR_W-1:0] missAddr,
  input logic              memIdle,
  input logic              pfValid,
  input logic [ADDR_W-1:0] pfAddr,
  input logic              pfReady
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);

  logic sameBlk;
  assign sameBlk = missValid && (missAddr[ADDR_W-1:OFF_W] == pfAddr[ADDR_W-1:OFF_W]);

  // R7: request held until accepted
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && !pfReady && !sameBlk |=> pfValid && $stable(pfAddr));

  // R8: duplicate of a demand miss is withdrawn
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && sameBlk |=> !pfValid);

  // R6: loads only on an idle, miss-free cycle
  p_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfValid) |-> $past(memIdle) && !$past(missValid));

  // R6: no reload in the cycle a request is accepted
  p_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && pfReady |=> !pfValid);
endmodule

bind streamPrefetcher streamPrefetcherChk #(
  .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
  .memIdle(memIdle), .pfValid(pfValid), .pfAddr(pfAddr), .pfReady(pfReady)
);

// File: tb/sim_streamPrefetcher.sv
module sim_streamPrefetcher;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        memIdle = 1'b0;
  logic        pfValid;
  logic [31:0] pfAddr;
  logic        pfReady = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] expQ[$];
  string curTag = "R4";

  streamPrefetcher u0 (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .memIdle(memIdle), .pfValid(pfValid), .pfAddr(pfAddr), .pfReady(pfReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: every accepted request must match the head of the queue
  always @(negedge clk) begin
    cycles++;
    if (rstN && pfValid && pfReady) begin
      if (expQ.size() == 0) chk(1'b0, {curTag, " unexpected request"}, pfAddr, 32'hFFFF_FFFF);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        chk(pfAddr == e, curTag, pfAddr, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic doReset();
    rstN = 1'b0; missValid = 1'b0; memIdle = 1'b0; pfReady = 1'b1;
    expQ.delete();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic miss(input logic [31:0] a);
    @(negedge clk);
    missValid = 1'b1; missAddr = a;
    @(negedge clk);
    missValid = 1'b0;
  endtask

  // Watch pfValid for n cycles; one check
  task automatic quiet(input int n, input bit idle, input string tag);
    bit seen = 1'b0;
    memIdle = idle;
    repeat (n) begin
      @(negedge clk);
      if (pfValid) seen = 1'b1;
    end
    memIdle = 1'b0;
    chk(!seen, tag, {31'b0, seen}, 32'h0);
  endtask

  task automatic pushRun(input logic [31:0] page, input int first, input int last);
    for (int b = first; b <= last; b++) expQ.push_back((page << 12) | (b << 6));
  endtask

  task automatic pushDown(input logic [31:0] page, input int first, input int last);
    for (int b = first; b >= last; b--) expQ.push_back((page << 12) | (b << 6));
  endtask

  task automatic drain(input string tag);
    int n = 0;
    curTag = tag;
    memIdle = 1'b1;
    while (expQ.size() != 0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    repeat (12) @(negedge clk);
    chk(expQ.size() == 0, {tag, " all expected requests seen"}, expQ.size(), 0);
    chk(!pfValid, {tag, " nothing further after stream end"}, {31'b0, pfValid}, 0);
    memIdle = 1'b0;
  endtask

  initial begin
    // R1: reset state
    doReset();
    chk(!pfValid, "R1 pfValid after reset", {31'b0, pfValid}, 0);
    quiet(10, 1'b1, "R1 no request from empty table");

    // Ascending stream near page end (R2, R3, R4, R5, R6, R11)
    miss(32'h0001_0E80);                       // block 58
    quiet(15, 1'b1, "R2 single miss stays training");
    miss(32'h0001_0F00);                       // block 60, distance 2
    quiet(15, 1'b0, "R6 no request while memory busy");
    pushRun(32'h10, 61, 63);
    drain("R4/R5/R11 ascending to page end");

    // Descending stream to block 0 (R4, R5)
    doReset();
    miss(32'h0002_00C0);                       // block 3
    miss(32'h0002_0080);                       // block 2
    pushDown(32'h20, 1, 0);
    drain("R4/R5 descending to page start");

    // Trigger distance rules (R3)
    doReset();
    miss(32'h0003_0F00);                       // block 60
    miss(32'h0003_0E00);                       // block 56, distance 4
    quiet(15, 1'b1, "R3 distance of four blocks does not trigger");
    miss(32'h0003_0E10);                       // block 56 again, distance 0
    quiet(15, 1'b1, "R3 same block does not trigger");
    miss(32'h0003_0E40);                       // block 57, distance 1 from 56
    pushRun(32'h30, 58, 63);
    drain("R3 newest miss is the reference");

    // LRU replacement (R9)
    doReset();
    for (int k = 0; k < 8; k++) miss(((32'h100 + k) << 12) | 32'h280);
    miss(32'h0010_0280);                       // touch page 0x100 again
    miss(32'h0010_8280);                       // ninth page evicts 0x101
    miss(32'h0010_12C0);                       // 0x101 block 11: history lost
    quiet(15, 1'b1, "R9 least recent tracker was replaced");
    miss(32'h0010_02C0);                       // 0x100 block 11: survived
    pushRun(32'h100, 12, 63);
    drain("R9 recently touched tracker kept");

    // Hold, cancel and re-anchor (R7, R8, R10)
    doReset();
    pfReady = 1'b0;
    memIdle = 1'b1;
    miss(32'h0004_0280);                       // block 10
    miss(32'h0004_02C0);                       // block 11
    @(negedge clk);
    chk(pfValid && pfAddr == 32'h0004_0300, "R11 first request block 12", pfAddr, 32'h0004_0300);
    repeat (2) @(negedge clk);
    chk(pfValid && pfAddr == 32'h0004_0300, "R7 request held without ready", pfAddr, 32'h0004_0300);
    missValid = 1'b1; missAddr = 32'h0004_0310;  // same block as request
    @(negedge clk);
    missValid = 1'b0;
    chk(!pfValid, "R8 duplicate request withdrawn", {31'b0, pfValid}, 0);
    @(negedge clk);
    chk(pfValid && pfAddr == 32'h0004_0340, "R10 reload after re-anchor", pfAddr, 32'h0004_0340);
    miss(32'h0004_0780);                       // block 30, unrelated to pending
    chk(pfValid && pfAddr == 32'h0004_0340, "R7 held across unrelated miss", pfAddr, 32'h0004_0340);
    expQ.push_back(32'h0004_0340);
    pushRun(32'h40, 31, 63);
    pfReady = 1'b1;
    drain("R10 stream continues past re-anchor");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule